// File: doc/BRIEF.md
# Line-Sequential Calibration Set Selector

This block sits between a front end's per-channel calibration storage and its nine gain/offset datapaths. It decides which stored parameter set (analog gain, digital gain and offset code) feeds each channel. In normal mode every channel uses its own set. For sensors that deliver one whole colour per line, a shared mode makes all nine channels use one common set. That set is taken from the last three channels' storage, which act as three colour slots.

The shared slot is chosen in one of two ways. A static 2-bit selector can name it directly. Or the block can rotate through the three slots, one step per line sync pulse, so that each colour line gets its own calibration without software stepping in. The selection is held in registers, and the per-channel outputs are registered too. As a result the parameters seen by the datapath change only after a control write or a sampled line sync, never partway through a line.

Top module: `calset_select`

## Requirements
- R1: After synchronous reset the control byte reads 0x00, every channel carries its own set one clock later, and the rotation pointer sits on the first colour slot (channel 7's set).
- R2: With the shared-mode bit (control bit 0) low, channel k outputs the analog gain, digital gain and offset of stored set k, for all nine channels.
- R3: With shared mode on and rotation off, the selector field (control bits 3:2) puts one set on every channel: 00 gives channel 7's set, 01 gives channel 8's set and 10 gives channel 9's set. All three members always come from the same set.
- R4: A write of selector code 11 leaves the selector field, and with it the selection, unchanged and sets a sticky error bit (read-back bit 4). Later writes keep the bit set. Only a write to the control address with bit 4 high clears it, and a code-11 write that also has bit 4 high still leaves it set.
- R5: With shared mode and rotation (control bit 1) both on, each sampled line sync pulse steps the shared set 7 → 8 → 9 → 7.
- R6: A write that turns rotation from off to on restarts it at channel 7's set. A write that leaves rotation on keeps the current position.
- R7: Line sync pulses that arrive while shared mode is off do not move the rotation position.
- R8: The selection changes only on a clock edge where a control write or a line sync pulse is sampled.
- R9: Writes to any address other than the control address (0x23) change neither the control byte nor the outputs.
- R10: Read-back data is {3'b000, error, selector[1:0], rotate, shared}.
- R11: Outputs are registered: a selection change made at one edge shows on the outputs after the next edge, and in normal mode the outputs follow the stored sets with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Control byte and error flag read-back |
| line_sync | input | 1 | Single-cycle line start pulse |
| ana_gain_in | input | 72 | Nine stored analog gains, channel k at bits [8k+7:8k] |
| dig_gain_in | input | 81 | Nine stored digital gains, channel k at bits [9k+8:9k] |
| ofs_in | input | 72 | Nine stored offset codes, channel k at bits [8k+7:8k] |
| ana_gain_out | output | 72 | Selected analog gain per channel |
| dig_gain_out | output | 81 | Selected digital gain per channel |
| ofs_out | output | 72 | Selected offset code per channel |

## Verification
Every stored set carries values unique to its channel in all three members, so any mix-up of channel, slot or member shows as a wrong value. The bench drives normal mode, each static code, the reserved code, rotation across a full wrap, and rotation restarted from mid-sequence. Line syncs are also sent while shared mode is off, and the bench then switches shared mode on without a rotation edge. This separates a pointer that counted those syncs from one that held still. Writes to a foreign address and a sample taken between the two register stages check that nothing moves outside the defined edges.

// File: rtl/calset_pkg.sv
package calset_pkg;
  typedef enum logic [1:0] {
    SEL_SLOT_A = 2'b00,
    SEL_SLOT_B = 2'b01,
    SEL_SLOT_C = 2'b10,
    SEL_RSVD   = 2'b11
  } slot_sel_e;

  // Packed in read-back order: {err, sel, rotate, shared}
  typedef struct packed {
    logic      err;
    slot_sel_e sel;
    logic      rotate;
    logic      shared;
  } ctrl_t;

  localparam int SHARED_BIT = 0;
  localparam int ROTATE_BIT = 1;
  localparam int SEL_LSB    = 2;
  localparam int ERR_BIT    = 4;
  localparam int NUM_SLOTS  = 3;
endpackage

// File: rtl/calset_ctrl.sv
module calset_ctrl
  import calset_pkg::*;
#(
  parameter int             AW       = 8,
  parameter logic [AW-1:0]  CFG_ADDR = 8'h23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output ctrl_t         ctrl_q,
  output logic          rotate_start,
  output logic [7:0]    rdata
);
  logic      hit;
  slot_sel_e wsel;
  logic      unused_wbits;

  assign hit          = cfg_we && (cfg_addr == CFG_ADDR);
  assign wsel         = slot_sel_e'(cfg_wdata[SEL_LSB +: 2]);
  assign unused_wbits = ^cfg_wdata[7:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (hit) begin
      ctrl_q.shared <= cfg_wdata[SHARED_BIT];
      ctrl_q.rotate <= cfg_wdata[ROTATE_BIT];
      if (wsel != SEL_RSVD) ctrl_q.sel <= wsel;
      if (wsel == SEL_RSVD) ctrl_q.err <= 1'b1;
      else if (cfg_wdata[ERR_BIT]) ctrl_q.err <= 1'b0;
    end
  end

  assign rotate_start = hit && cfg_wdata[ROTATE_BIT] && !ctrl_q.rotate;
  assign rdata        = {3'b000, ctrl_q};
endmodule

// File: rtl/calset_cycler.sv
module calset_cycler
  import calset_pkg::*;
#(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step_en,
  input  logic          line_sync,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NUM_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ptr <= '0;
    end else if (line_sync && step_en) begin
      ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
    end
  end
endmodule

// File: rtl/calset_chmux.sv
module calset_chmux #(
  parameter int NCH  = 9,
  parameter int AGW  = 8,
  parameter int DGW  = 9,
  parameter int OW   = 8,
  parameter int IDXW = 4,
  parameter int CH   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shared,
  input  logic [IDXW-1:0]   shared_idx,
  input  logic [NCH*AGW-1:0] ana_in,
  input  logic [NCH*DGW-1:0] dig_in,
  input  logic [NCH*OW-1:0]  ofs_in,
  output logic [AGW-1:0]    ana_out,
  output logic [DGW-1:0]    dig_out,
  output logic [OW-1:0]     ofs_out
);
  logic [IDXW-1:0] sel;
  assign sel = shared ? shared_idx : IDXW'(CH);

  // One index drives all three members so they switch together
  always_ff @(posedge clk) begin
    if (rst) begin
      ana_out <= '0;
      dig_out <= '0;
      ofs_out <= '0;
    end else begin
      ana_out <= ana_in[int'(sel)*AGW +: AGW];
      dig_out <= dig_in[int'(sel)*DGW +: DGW];
      ofs_out <= ofs_in[int'(sel)*OW  +: OW];
    end
  end
endmodule

// File: rtl/calset_select.sv
module calset_select
  import calset_pkg::*;
#(
  parameter int            NCH      = 9,
  parameter int            AGW      = 8,
  parameter int            DGW      = 9,
  parameter int            OW       = 8,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               line_sync,
  input  logic [NCH*AGW-1:0] ana_gain_in,
  input  logic [NCH*DGW-1:0] dig_gain_in,
  input  logic [NCH*OW-1:0]  ofs_in,
  output logic [NCH*AGW-1:0] ana_gain_out,
  output logic [NCH*DGW-1:0] dig_gain_out,
  output logic [NCH*OW-1:0]  ofs_out
);
  localparam int              IDXW = $clog2(NCH);
  localparam int              PW   = 2;
  localparam logic [IDXW-1:0] BASE = IDXW'(NCH - NUM_SLOTS);

  ctrl_t           ctrl_q;
  logic            rotate_start;
  logic [PW-1:0]   ptr;
  logic [PW-1:0]   slot;
  logic [IDXW-1:0] shared_idx;

  calset_ctrl #(.AW(AW), .CFG_ADDR(CFG_ADDR)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .ctrl_q       (ctrl_q),
    .rotate_start (rotate_start),
    .rdata        (cfg_rdata)
  );

  calset_cycler #(.PW(PW)) u_cyc (
    .clk       (clk),
    .rst       (rst),
    .restart   (rotate_start),
    .step_en   (ctrl_q.shared && ctrl_q.rotate),
    .line_sync (line_sync),
    .ptr       (ptr)
  );

  assign slot       = ctrl_q.rotate ? ptr : PW'(ctrl_q.sel);
  assign shared_idx = BASE + IDXW'(slot);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    calset_chmux #(
      .NCH(NCH), .AGW(AGW), .DGW(DGW), .OW(OW), .IDXW(IDXW), .CH(g)
    ) u_mux (
      .clk        (clk),
      .rst        (rst),
      .shared     (ctrl_q.shared),
      .shared_idx (shared_idx),
      .ana_in     (ana_gain_in),
      .dig_in     (dig_gain_in),
      .ofs_in     (ofs_in),
      .ana_out    (ana_gain_out[g*AGW +: AGW]),
      .dig_out    (dig_gain_out[g*DGW +: DGW]),
      .ofs_out    (ofs_out[g*OW +: OW])
    );
  end
endmodule

// File: rtl/calset_checker.sv
module calset_checker #(
  parameter int            IDXW     = 4,
  parameter int            AGW      = 8,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h23,
  parameter logic [IDXW-1:0] BASE   = 4'd6
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [AW-1:0]   cfg_addr,
  input logic [1:0]      wr_sel,
  input logic            wr_clr,
  input logic            line_sync,
  input logic            shared,
  input logic            rotate,
  input logic            err,
  input logic [1:0]      sel,
  input logic [1:0]      ptr,
  input logic [IDXW-1:0] shared_idx,
  input logic [AGW-1:0]  ana_in0,
  input logic [AGW-1:0]  ana_out0
);
  logic ctl_hit;
  assign ctl_hit = cfg_we && (cfg_addr == CFG_ADDR);

  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
    shared |-> (shared_idx >= BASE) && (shared_idx <= BASE + IDXW'(2)));

  p_err_set_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_hit && (wr_sel == 2'b11) |=> err && $stable(sel));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    err && !(ctl_hit && wr_clr) |=> err);

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    shared && rotate && line_sync && !cfg_we |=>
      ptr == (($past(ptr) == 2'd2) ? 2'd0 : $past(ptr) + 2'd1));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !shared && line_sync && !cfg_we |=> $stable(ptr));

  p_sel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !line_sync && !cfg_we |=> $stable(shared_idx) && $stable(shared));

  p_out_reg_r11: assert property (@(posedge clk) disable iff (rst)
    !shared |=> ana_out0 == $past(ana_in0));
endmodule

bind calset_select calset_checker #(
  .IDXW(IDXW), .AGW(AGW), .AW(AW), .CFG_ADDR(CFG_ADDR), .BASE(BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .wr_sel     (cfg_wdata[3:2]),
  .wr_clr     (cfg_wdata[4]),
  .line_sync  (line_sync),
  .shared     (ctrl_q.shared),
  .rotate     (ctrl_q.rotate),
  .err        (ctrl_q.err),
  .sel        (ctrl_q.sel),
  .ptr        (ptr),
  .shared_idx (shared_idx),
  .ana_in0    (ana_gain_in[AGW-1:0]),
  .ana_out0   (ana_gain_out[AGW-1:0])
);

// File: tb/sim_calset_select.sv
`timescale 1ns/1ps
module sim_calset_select;
  localparam int NCH = 9, AGW = 8, DGW = 9, OW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, line_sync = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
  logic [NCH*AGW-1:0] ana_in, ana_out;
  logic [NCH*DGW-1:0] dig_in, dig_out;
  logic [NCH*OW-1:0]  ofs_in, ofs_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  calset_select u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .line_sync(line_sync),
    .ana_gain_in(ana_in), .dig_gain_in(dig_in), .ofs_in(ofs_in),
    .ana_gain_out(ana_out), .dig_gain_out(dig_out), .ofs_out(ofs_out)
  );

  function automatic logic [AGW-1:0] av(int k); return AGW'(8'h10 + k); endfunction
  function automatic logic [DGW-1:0] dv(int k); return DGW'(9'h1A0 + k); endfunction
  function automatic logic [OW-1:0]  ov(int k); return OW'(8'hC0 + k); endfunction

  // set < 0: every channel its own set; else stored set index 'set' everywhere
  task automatic chk_sel(int set, string req);
    bit bad = 0;
    checks++;
    for (int ch = 0; ch < NCH; ch++) begin
      int k = (set < 0) ? ch : set;
      if (!bad && (ana_out[ch*AGW +: AGW] !== av(k) || dig_out[ch*DGW +: DGW] !== dv(k)
                   || ofs_out[ch*OW +: OW] !== ov(k))) begin
        bad = 1; errors++;
        $display("FAIL %s ch%0d actual=%h/%h/%h expected=%h/%h/%h", req, ch,
                 ana_out[ch*AGW +: AGW], dig_out[ch*DGW +: DGW], ofs_out[ch*OW +: OW],
                 av(k), dv(k), ov(k));
      end
    end
  endtask

  task automatic chk_rd(logic [7:0] exp, string req);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", req, cfg_rdata, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic sync_pulse();
    @(negedge clk); line_sync = 1;
    @(negedge clk); line_sync = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk_rd(8'h00, "R1 reset control");
    chk_sel(-1, "R1 reset own sets");
  endtask

  task automatic t_normal();
    wr(8'h23, 8'h08);              // shared off, selector 10
    chk_sel(-1, "R2 normal ignores selector");
    chk_rd(8'h08, "R10 readback");
  endtask

  task automatic t_static();
    wr(8'h23, 8'h01); chk_sel(6, "R3 code 00 -> ch7 set");
    wr(8'h23, 8'h05); chk_sel(7, "R3 code 01 -> ch8 set");
    wr(8'h23, 8'h09); chk_sel(8, "R3 code 10 -> ch9 set");
  endtask

  task automatic t_reserved();
    wr(8'h23, 8'h0D);              // code 11
    chk_sel(8, "R4 reserved keeps selection");
    chk_rd(8'h19, "R4 error set");
    wr(8'h23, 8'h05);
    chk_rd(8'h15, "R4 error sticky");
    chk_sel(7, "R4 later valid write applies");
    wr(8'h23, 8'h1D);              // code 11 with clear bit
    chk_rd(8'h15, "R4 set wins over clear");
    wr(8'h23, 8'h15);
    chk_rd(8'h05, "R4 clear");
  endtask

  task automatic t_cycle();
    wr(8'h23, 8'h03);
    chk_sel(6, "R5 rotation start ch7");
    sync_pulse(); chk_sel(7, "R5 step to ch8");
    repeat (4) @(negedge clk);
    chk_sel(7, "R8 no change without sync");
    sync_pulse(); chk_sel(8, "R5 step to ch9");
    sync_pulse(); chk_sel(6, "R5 wrap to ch7");
  endtask

  task automatic t_restart();
    sync_pulse(); sync_pulse();    // at ch9
    wr(8'h23, 8'h05); chk_sel(7, "R6 rotation off uses selector");
    wr(8'h23, 8'h03); chk_sel(6, "R6 restart at ch7");
    sync_pulse();
    wr(8'h23, 8'h07); chk_sel(7, "R6 rewrite with rotation on keeps position");
  endtask

  task automatic t_sync_ignored();
    wr(8'h23, 8'h00);
    wr(8'h23, 8'h02);              // rotation on, shared off: restart at 0
    sync_pulse(); sync_pulse();
    chk_sel(-1, "R7 shared off outputs own");
    wr(8'h23, 8'h03);
    chk_sel(6, "R7 syncs did not move pointer");
  endtask

  task automatic t_other_addr();
    wr(8'h24, 8'h09);
    chk_rd(8'h03, "R9 foreign address control");
    chk_sel(6, "R9 foreign address outputs");
  endtask

  task automatic t_latency();
    @(negedge clk); cfg_we = 1; cfg_addr = 8'h23; cfg_wdata = 8'h05;
    @(negedge clk); cfg_we = 0;
    chk_sel(6, "R11 old set one edge after write");
    @(negedge clk);
    chk_sel(7, "R11 new set two edges after write");
    wr(8'h23, 8'h00);
    @(negedge clk); ana_in[AGW-1:0] = 8'h5A;
    @(negedge clk);
    checks++;
    if (ana_out[AGW-1:0] !== 8'h5A) begin
      errors++;
      $display("FAIL R11 follow actual=%h expected=5a", ana_out[AGW-1:0]);
    end
    ana_in[AGW-1:0] = av(0);
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin
      ana_in[k*AGW +: AGW] = av(k);
      dig_in[k*DGW +: DGW] = dv(k);
      ofs_in[k*OW  +: OW]  = ov(k);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_normal();
    t_static();
    t_reserved();
    t_cycle();
    t_restart();
    t_sync_ignored();
    t_other_addr();
    t_latency();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule